// File: doc/BRIEF.md
# Carry-Bypass Group Adder

A purely combinational binary adder that splits its operands into equal groups of bits. A setup stage classifies every bit position from the two operand bits. Each bit is marked as generating a carry when both bits are 1, propagating an incoming carry when exactly one bit is 1, and killing it when both bits are 0. Inside a group the carry ripples from bit to bit, and each sum bit is the propagate flag of its position XORed with the carry arriving there.

Alongside the ripple, each group forms a skip condition: the AND of all of its propagate flags. When that condition holds, a multiplexer hands the group's incoming carry straight to the next group, so a long propagate run crosses whole groups in one mux delay. When it does not hold, the group's own ripple result is passed on. The carry leaving the last group is the adder's carry-out.

The default is a 16-bit adder made of four 4-bit groups. The group width is a parameter and must divide the total width.

Top module: `cbAdder`

## Requirements
- R1: `{cout, sum}` equals the 17-bit value `a + b + cin` for every input combination.
- R2: When all bits of a group have exactly one operand bit set (propagate), the carry leaving that group equals the carry entering it. With `a = 16'hFFFF`, `b = 0`, the result is `sum = 16'hFFFF`, `cout = 0` for `cin = 0`, and `sum = 0`, `cout = 1` for `cin = 1`.
- R3: When both operand bits are 0 in every bit of a group (kill), the carry leaving that group is 0, whatever carry enters it.
- R4: When both operand bits are 1 in the most significant bit of a group (generate), the carry leaving that group is 1.
- R5: `cout` is the carry leaving the most significant group, including the overflow cases `16'hFFFF + 16'hFFFF + 1` and `16'h8000 + 16'h8000`.
- R6: The group width is a parameter (default 4) that must divide the total width. Any legal group width yields results identical to the default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of the top group |

## Verification
All-zero operands confirm the idle result. The all-propagate operand `16'hFFFF` with both carry-in values shows that every skip multiplexer forwards the incoming carry, which a stuck bypass select would break. Per-group propagate runs fed by a low-order carry, kill blocks placed after a carry-producing group, and generate bits at each group's top tell the skip path apart from the ripple path, and from the kill and generate cases. Overflow corners and random vectors are checked against the default build and against a 2-bit-group build, which separates carry errors tied to group width from plain arithmetic errors.

// File: rtl/adder_pkg.sv
package adder_pkg;
  // Classification of one bit position from its two operand bits.
  typedef struct packed {
    logic gen;   // both bits set: a carry is created here
    logic prop;  // exactly one bit set: incoming carry passes through
    logic kill;  // both bits clear: incoming carry is absorbed
  } bitClass_t;
endpackage

// File: rtl/cbSetup.sv
module cbSetup
  import adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]      a,
  input  logic [WIDTH-1:0]      b,
  output bitClass_t [WIDTH-1:0] bitInfo
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitInfo[i].gen  = a[i] & b[i];
    assign bitInfo[i].prop = a[i] ^ b[i];
    assign bitInfo[i].kill = ~a[i] & ~b[i];
  end
endmodule

// File: rtl/cbGroup.sv
module cbGroup
  import adder_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  bitClass_t [GROUP-1:0] info,
  input  logic                  carryIn,
  output logic [GROUP-1:0]      sumBits,
  output logic                  carryOut
);
  logic [GROUP:0]   rippleC;
  logic [GROUP-1:0] propVec;
  logic             skipSel;

  assign rippleC[0] = carryIn;

  for (genvar i = 0; i < GROUP; i++) begin : g_ripple
    assign propVec[i]     = info[i].prop;
    // A killed bit forces 0, a generating bit forces 1, otherwise pass along.
    assign rippleC[i+1]   = info[i].kill ? 1'b0 : (info[i].gen ? 1'b1 : rippleC[i]);
    assign sumBits[i]     = info[i].prop ^ rippleC[i];
  end

  // Skip path: the whole group propagates, so forward the entry carry.
  assign skipSel  = &propVec;
  assign carryOut = skipSel ? carryIn : rippleC[GROUP];
endmodule

// File: rtl/cbAdder.sv
module cbAdder
  import adder_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGROUPS = WIDTH / GROUP;

  if ((WIDTH % GROUP) != 0) begin : g_badCfg
    $error("cbAdder: WIDTH must be a multiple of GROUP");
  end

  bitClass_t [WIDTH-1:0] bitInfo;
  logic      [WIDTH-1:0] genBits;
  logic      [WIDTH-1:0] propBits;
  logic      [WIDTH-1:0] killBits;
  logic      [NGROUPS:0] grpCarry;

  cbSetup #(.WIDTH(WIDTH)) u_setup (
    .a       (a),
    .b       (b),
    .bitInfo (bitInfo)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_flat
    assign genBits[i]  = bitInfo[i].gen;
    assign propBits[i] = bitInfo[i].prop;
    assign killBits[i] = bitInfo[i].kill;
  end

  assign grpCarry[0] = cin;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    cbGroup #(.GROUP(GROUP)) u_group (
      .info     (bitInfo[g*GROUP +: GROUP]),
      .carryIn  (grpCarry[g]),
      .sumBits  (sum[g*GROUP +: GROUP]),
      .carryOut (grpCarry[g+1])
    );
  end

  assign cout = grpCarry[NGROUPS];
endmodule

// File: rtl/cbAdderChk.sv
module cbAdderChk #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input logic [WIDTH-1:0]         a,
  input logic [WIDTH-1:0]         b,
  input logic                     cin,
  input logic [WIDTH-1:0]         sum,
  input logic                     cout,
  input logic [WIDTH-1:0]         genBits,
  input logic [WIDTH-1:0]         propBits,
  input logic [WIDTH-1:0]         killBits,
  input logic [WIDTH/GROUP:0]     grpCarry
);
  localparam int NGROUPS = WIDTH / GROUP;

  always_comb begin
    // R1
    sum_match_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    // R5
    cout_last_chk: assert (cout == grpCarry[NGROUPS]);
    for (int g = 0; g < NGROUPS; g++) begin
      // R2
      skip_pass_chk: assert (!(&propBits[g*GROUP +: GROUP]) || (grpCarry[g+1] == grpCarry[g]));
      // R3
      kill_block_chk: assert (!(&killBits[g*GROUP +: GROUP]) || !grpCarry[g+1]);
      // R4
      gen_top_chk: assert (!genBits[g*GROUP + GROUP - 1] || grpCarry[g+1]);
    end
  end
endmodule

bind cbAdder cbAdderChk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .genBits  (genBits),
  .propBits (propBits),
  .killBits (killBits),
  .grpCarry (grpCarry)
);

// File: tb/test_cbAdder.sv
module test_cbAdder;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sumD, sumN;
  logic         coutD, coutN;

  int testCnt = 0;
  int failCnt = 0;
  logic [W:0] expQ [$];
  string      tagQ [$];

  cbAdder #(.WIDTH(W), .GROUP(4)) i_cbAdder (
    .a(a), .b(b), .cin(cin), .sum(sumD), .cout(coutD)
  );
  // R6: narrower groups must give the same results
  cbAdder #(.WIDTH(W), .GROUP(2)) i_cbAdderG2 (
    .a(a), .b(b), .cin(cin), .sum(sumN), .cout(coutN)
  );

  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input string tag);
    @(negedge clk);
    a   = va;
    b   = vb;
    cin = vc;
    expQ.push_back({1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc});
    tagQ.push_back(tag);
  endtask

  // Monitor: inputs change on the falling edge, results are taken on the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      if (expQ.size() > 0) begin
        logic [W:0] exp;
        string      tag;
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        testCnt++;
        if ({coutD, sumD} !== exp) begin
          failCnt++;
          $display("FAIL %s group4: got %h expected %h", tag, {coutD, sumD}, exp);
        end
        testCnt++;
        if ({coutN, sumN} !== exp) begin
          failCnt++;
          $display("FAIL %s R6 group2: got %h expected %h", tag, {coutN, sumN}, exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    // R1: idle operands
    drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
    // R2: every group propagates
    drive(16'hFFFF, 16'h0000, 1'b0, "R2 allprop cin0");
    drive(16'hFFFF, 16'h0000, 1'b1, "R2 allprop cin1");
    drive(16'h0000, 16'hFFFF, 1'b1, "R2 allprop swapped");
    drive(16'h5A5A, 16'hA5A5, 1'b1, "R2 mixed prop");
    // R2: propagate run in one group fed by a carry from below
    for (int g = 1; g < 4; g++) begin
      drive(16'((32'hF << (4*g)) | ((32'h1 << (4*g)) - 1)), 16'h0001, 1'b0, "R2 group run");
      drive(16'(32'hF << (4*g)), 16'h0000, 1'b1, "R2 group run nocarry");
    end
    // R3: kill groups after a carry-producing group
    drive(16'hF00F, 16'h0001, 1'b1, "R3 kill mid");
    drive(16'h000F, 16'h000F, 1'b1, "R3 kill upper");
    drive(16'h0FFF, 16'h0001, 1'b0, "R3 kill top");
    // R4: generate at each group's top bit
    drive(16'h8888, 16'h8888, 1'b0, "R4 gen tops");
    drive(16'h0808, 16'h0800, 1'b1, "R4 gen one");
    // R5: overflow corners
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R5 max");
    drive(16'h8000, 16'h8000, 1'b0, "R5 msb");
    drive(16'h7FFF, 16'h0000, 1'b1, "R5 edge");
    // R1/R6: random vectors
    for (int i = 0; i < 300; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    end
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule